// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the five status flags of a clocked serial port that can act as master or slave, with an optional chip-select line in four-wire operation. The flags are transmit buffer empty, transmission finished, receive buffer full, receive overrun and chip-select conflict. Two sources update them. The first is the bus side: writes of the transmit data register, reads of the receive data register, and reads and writes of the status register itself. The second is a set of single-cycle strobes from the serial shift engine: byte loaded into the shifter, final bit shifted, byte received, transfer started, transfer active.

Software clears a flag in two steps. It first reads the status register while the flag is 1, which arms that flag. A later status write with a 0 in that position then clears it. Writing 1 does nothing. A hardware set that lands in the same cycle as a clear wins.

While an overrun is pending, the block raises a transfer-inhibit output and ignores every engine strobe.

Top module: `ssp_status_flags`

## Requirements
- R1: After reset, all flags are 0, `stat_rdata` reads 0x00 and `xfer_inhibit` is 0.
- R2: `stat_rdata` places the flags at fixed bits: conflict at bit 0, overrun at bit 2, receive-full at bit 5, transmit-end at bit 6 and transmit-empty at bit 7. Bits 1, 3 and 4 always read 0.
- R3: Transmit-empty becomes 1 in the cycle after `tx_en` rises. It also becomes 1 in the cycle after an `eng_load` strobe. A level on `tx_en` that is held high does not set it again.
- R4: A `bus_wr_txd` pulse clears both transmit-empty and transmit-end on the next clock edge.
- R5: An `eng_last_bit` strobe sets transmit-end only when transmit-empty is already 1. Otherwise transmit-end stays 0.
- R6: An `eng_rx_done` strobe sets receive-full. A `bus_rd_rxd` pulse clears it.
- R7: An `eng_rx_done` strobe that arrives while receive-full is 1 sets overrun. While overrun is 1:
  - `xfer_inhibit` is 1;
  - the strobes `eng_load`, `eng_last_bit`, `eng_rx_done` and `eng_xfer_start` have no effect on any flag;
  - chip-select edges have no effect on any flag.
- R8: In four-wire master mode (`four_wire`=1, `is_master`=1), an `eng_xfer_start` strobe while `cs_in` is 0 sets the conflict flag. When `cs_in` is 1, or when `four_wire` is 0, the strobe does not set it.
- R9: In four-wire slave mode (`four_wire`=1, `is_master`=0), a 0-to-1 change of `cs_in` while `eng_xfer_active` is 1 sets the conflict flag. The same change with `eng_xfer_active` at 0 does not set it.
- R10: A status write leaves a flag at 1 if the write carries a 1 in that flag's bit. It also leaves the flag at 1 if the write carries a 0 but the flag was not read as 1 since the last status write.
- R11: A status read that returns a flag as 1 arms that flag. The next status write with a 0 in its bit clears it. Any status write consumes all arms.
- R12: A hardware set event in the same cycle as an armed software clear leaves the flag at 1. The arm is consumed, so a further write of 0 without a new read leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable level |
| four_wire | input | 1 | 1 = chip-select (four-wire) operation |
| is_master | input | 1 | 1 = master, 0 = slave |
| cs_in | input | 1 | Chip-select input level (already synchronised) |
| bus_rd_stat | input | 1 | Status register read pulse |
| bus_wr_stat | input | 1 | Status register write pulse |
| bus_wdata | input | REG_W | Status write data |
| bus_wr_txd | input | 1 | Transmit data register write pulse |
| bus_rd_rxd | input | 1 | Receive data register read pulse |
| eng_load | input | 1 | Transmit byte moved into shift register |
| eng_last_bit | input | 1 | Final bit of a frame shifted out |
| eng_rx_done | input | 1 | A received byte is complete |
| eng_xfer_start | input | 1 | Transfer start strobe |
| eng_xfer_active | input | 1 | Transfer in progress level |
| stat_rdata | output | REG_W | Status register read value |
| xfer_inhibit | output | 1 | Stop all transfers (overrun pending) |

## Verification
Transmit events are applied in both orders: final bit before and after the data register write. This separates the transmit-end gating from the plain set. Receive strobes arrive with the buffer empty and again with it full, which separates a normal receive from an overrun. Further strobes during the overrun show whether the inhibit actually freezes the flags.

The clear protocol is tried in several ways:
- a write of 0 without a prior read;
- a write of 1;
- a read followed by a write;
- a read followed by a write that coincides with a hardware set.

These show whether the arm is recorded, consumed and overridden. Chip-select patterns in master, slave and three-wire settings, with the transfer both idle and active, separate the two conflict rules from each other.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int NUM_FLAGS = 5;

    localparam int IDX_CONF = 0;
    localparam int IDX_OVR  = 1;
    localparam int IDX_RXF  = 2;
    localparam int IDX_TXE  = 3;
    localparam int IDX_TXMT = 4;

    // Bit position of each flag in the status word (software decodes these)
    function automatic int flag_pos(input int idx);
        case (idx)
            IDX_CONF: return 0;
            IDX_OVR:  return 2;
            IDX_RXF:  return 5;
            IDX_TXE:  return 6;
            default:  return 7;
        endcase
    endfunction

    typedef struct packed {
        logic flag;
        logic arm;
    } flag_state_t;

    typedef struct packed {
        logic tx_en;
    } gate_state_t;

    typedef struct packed {
        logic cs;
    } cs_state_t;

endpackage

// File: rtl/ssp_flag_cell.sv
module ssp_flag_cell
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic hw_clr,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wr_bit,
    output logic flag_o
);

    flag_state_t st_q, st_d;
    logic        sw_clr;

    always_comb begin
        sw_clr     = wr_stat & ~wr_bit & st_q.arm;
        st_d.flag  = set_evt | (st_q.flag & ~hw_clr & ~sw_clr);
        // arm records a read of 1; any write consumes it; a zero flag drops it
        st_d.arm   = ~wr_stat & st_d.flag & (st_q.arm | (rd_stat & st_q.flag));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_WRITE_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && wr_stat && wr_bit && !hw_clr) |=> st_q.flag); // R10

    AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm && !hw_clr) |=> st_q.flag); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> st_q.flag); // R12

    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> !st_q.arm); // R11

endmodule

// File: rtl/ssp_edge_gate.sv
module ssp_edge_gate
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    input  logic tx_en,
    input  logic eng_load,
    input  logic eng_last_bit,
    input  logic eng_rx_done,
    input  logic eng_xfer_start,
    output logic tx_en_rise,
    output logic load_g,
    output logic last_g,
    output logic rx_g,
    output logic start_g
);

    gate_state_t st_q, st_d;

    always_comb begin
        st_d.tx_en = tx_en;
        tx_en_rise = tx_en & ~st_q.tx_en;
        load_g     = eng_load       & ~inhibit;
        last_g     = eng_last_bit   & ~inhibit;
        rx_g       = eng_rx_done    & ~inhibit;
        start_g    = eng_xfer_start & ~inhibit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_rise |=> !tx_en_rise); // R3

endmodule

// File: rtl/ssp_cs_conflict.sv
module ssp_cs_conflict
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    input  logic four_wire,
    input  logic is_master,
    input  logic cs_in,
    input  logic xfer_active,
    input  logic start_g,
    output logic conflict_evt
);

    cs_state_t st_q, st_d;
    logic      master_hit;
    logic      slave_hit;

    always_comb begin
        st_d.cs    = cs_in;
        master_hit = four_wire & is_master & start_g & ~cs_in;
        slave_hit  = four_wire & ~is_master & xfer_active & ~inhibit & ~st_q.cs & cs_in;
        conflict_evt = master_hit | slave_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs: 1'b1};
        else        st_q <= st_d;
    end

    AST_SLAVE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !xfer_active) |-> !conflict_evt); // R9

endmodule

// File: rtl/ssp_status_flags.sv
module ssp_status_flags
    import ssp_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             four_wire,
    input  logic             is_master,
    input  logic             cs_in,
    input  logic             bus_rd_stat,
    input  logic             bus_wr_stat,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             bus_wr_txd,
    input  logic             bus_rd_rxd,
    input  logic             eng_load,
    input  logic             eng_last_bit,
    input  logic             eng_rx_done,
    input  logic             eng_xfer_start,
    input  logic             eng_xfer_active,
    output logic [REG_W-1:0] stat_rdata,
    output logic             xfer_inhibit
);

    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_FLAGS; k++) m[flag_pos(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] USED_MASK = used_mask();

    logic [NUM_FLAGS-1:0] flag_vec;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] hwclr_vec;
    logic tx_en_rise, load_g, last_g, rx_g, start_g, conflict_evt;
    logic unused_wbits;

    assign unused_wbits = ^(bus_wdata & ~USED_MASK);
    assign xfer_inhibit = flag_vec[IDX_OVR];

    ssp_edge_gate u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .inhibit        (xfer_inhibit),
        .tx_en          (tx_en),
        .eng_load       (eng_load),
        .eng_last_bit   (eng_last_bit),
        .eng_rx_done    (eng_rx_done),
        .eng_xfer_start (eng_xfer_start),
        .tx_en_rise     (tx_en_rise),
        .load_g         (load_g),
        .last_g         (last_g),
        .rx_g           (rx_g),
        .start_g        (start_g)
    );

    ssp_cs_conflict u_conf (
        .clk          (clk),
        .rst_n        (rst_n),
        .inhibit      (xfer_inhibit),
        .four_wire    (four_wire),
        .is_master    (is_master),
        .cs_in        (cs_in),
        .xfer_active  (eng_xfer_active),
        .start_g      (start_g),
        .conflict_evt (conflict_evt)
    );

    always_comb begin
        set_vec   = '0;
        hwclr_vec = '0;
        set_vec[IDX_CONF]   = conflict_evt;
        set_vec[IDX_OVR]    = rx_g & flag_vec[IDX_RXF];
        set_vec[IDX_RXF]    = rx_g;
        set_vec[IDX_TXE]    = last_g & flag_vec[IDX_TXMT];
        set_vec[IDX_TXMT]   = tx_en_rise | load_g;
        hwclr_vec[IDX_RXF]  = bus_rd_rxd;
        hwclr_vec[IDX_TXE]  = bus_wr_txd;
        hwclr_vec[IDX_TXMT] = bus_wr_txd;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int P = flag_pos(i);
        ssp_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[i]),
            .hw_clr  (hwclr_vec[i]),
            .rd_stat (bus_rd_stat),
            .wr_stat (bus_wr_stat),
            .wr_bit  (bus_wdata[P]),
            .flag_o  (flag_vec[i])
        );
    end

    always_comb begin
        stat_rdata = '0;
        for (int k = 0; k < NUM_FLAGS; k++) stat_rdata[flag_pos(k)] = flag_vec[k];
    end

    AST_TXE_NEEDS_TXMT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[IDX_TXE]) |-> $past(flag_vec[IDX_TXMT])); // R5

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[IDX_OVR]) |-> $past(flag_vec[IDX_RXF])); // R7

    AST_OVR_FREEZES_RXF: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec[IDX_OVR] && !flag_vec[IDX_RXF]) |=> !flag_vec[IDX_RXF]); // R7

    AST_TXD_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_txd && !eng_last_bit) |=> !flag_vec[IDX_TXE]); // R4

    AST_CONF_FOUR_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[IDX_CONF]) |-> $past(four_wire)); // R8

endmodule

// File: tb/ssp_status_flags_test.sv
module ssp_status_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, four_wire = 1'b0, is_master = 1'b0, cs_in = 1'b1;
    logic       bus_rd_stat = 1'b0, bus_wr_stat = 1'b0, bus_wr_txd = 1'b0, bus_rd_rxd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       eng_load = 1'b0, eng_last_bit = 1'b0, eng_rx_done = 1'b0;
    logic       eng_xfer_start = 1'b0, eng_xfer_active = 1'b0;
    logic [7:0] stat_rdata;
    logic       xfer_inhibit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] stat;
        logic       inh;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    ssp_status_flags #(.REG_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .four_wire(four_wire),
        .is_master(is_master), .cs_in(cs_in), .bus_rd_stat(bus_rd_stat),
        .bus_wr_stat(bus_wr_stat), .bus_wdata(bus_wdata), .bus_wr_txd(bus_wr_txd),
        .bus_rd_rxd(bus_rd_rxd), .eng_load(eng_load), .eng_last_bit(eng_last_bit),
        .eng_rx_done(eng_rx_done), .eng_xfer_start(eng_xfer_start),
        .eng_xfer_active(eng_xfer_active), .stat_rdata(stat_rdata),
        .xfer_inhibit(xfer_inhibit)
    );

    // Monitor: results of the inputs set at a falling edge appear after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (stat_rdata !== it.stat || xfer_inhibit !== it.inh) begin
                    errors++;
                    $display("FAIL %s: stat=%02h inh=%0d expected stat=%02h inh=%0d",
                             it.tag, stat_rdata, xfer_inhibit, it.stat, it.inh);
                end
            end
        end
    end

    task automatic tick(input logic [7:0] es, input logic ei, input string tag);
        item_t it;
        it.stat = es;
        it.inh  = ei;
        it.tag  = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd_stat = 0; bus_wr_stat = 0; bus_wr_txd = 0; bus_rd_rxd = 0;
        eng_load = 0; eng_last_bit = 0; eng_rx_done = 0; eng_xfer_start = 0;
    endtask

    task automatic sw_clear(input logic [7:0] wdata, input logic [7:0] es, input logic ei, input string tag);
        bus_rd_stat = 1;
        tick(stat_rdata, xfer_inhibit, {tag, " read"});
        bus_wr_stat = 1; bus_wdata = wdata;
        tick(es, ei, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        tick(8'h00, 0, "R1 reset state");

        tx_en = 1;            tick(8'h80, 0, "R3 tx_en rise sets bit7 (R2)");
                              tick(8'h80, 0, "R3 held tx_en no change");
        eng_last_bit = 1;     tick(8'hC0, 0, "R5 last bit with empty sets bit6");
        bus_wr_txd = 1;       tick(8'h00, 0, "R4 txd write clears both");
        eng_last_bit = 1;     tick(8'h00, 0, "R5 last bit without empty");
        eng_load = 1;         tick(8'h80, 0, "R3 load sets empty");

        bus_wr_stat = 1; bus_wdata = 8'h00; tick(8'h80, 0, "R10 unarmed write 0");
        bus_wr_stat = 1; bus_wdata = 8'hFF; tick(8'h80, 0, "R10 write 1");
        sw_clear(8'h7F, 8'h00, 0, "R11 read then write 0 clears");

        eng_load = 1;         tick(8'h80, 0, "R3 load again");
        bus_rd_stat = 1;      tick(8'h80, 0, "R12 arm read");
        bus_wr_stat = 1; bus_wdata = 8'h00; eng_load = 1;
                              tick(8'h80, 0, "R12 set beats clear");
        bus_wr_stat = 1; bus_wdata = 8'h00; tick(8'h80, 0, "R12 arm consumed");
        bus_wr_txd = 1;       tick(8'h00, 0, "R4 txd write clears empty");

        eng_rx_done = 1;      tick(8'h20, 0, "R6 receive sets full (R2 bit5)");
        bus_rd_rxd = 1;       tick(8'h00, 0, "R6 rx read clears full");
        eng_rx_done = 1;      tick(8'h20, 0, "R6 receive again");
        eng_rx_done = 1;      tick(8'h24, 1, "R7 overrun and inhibit");
        eng_load = 1;         tick(8'h24, 1, "R7 load ignored");
        bus_rd_rxd = 1;       tick(8'h04, 1, "R6 rx read during overrun");
        eng_rx_done = 1;      tick(8'h04, 1, "R7 receive ignored");
        four_wire = 1; is_master = 1; cs_in = 0; eng_xfer_start = 1;
                              tick(8'h04, 1, "R7 start ignored");
        sw_clear(8'h00, 8'h00, 0, "R11 overrun cleared");

        eng_xfer_start = 1;   tick(8'h01, 0, "R8 master start with cs low");
        sw_clear(8'hFE, 8'h00, 0, "R11 conflict cleared");
        cs_in = 1; eng_xfer_start = 1; tick(8'h00, 0, "R8 master start cs high");
        four_wire = 0; cs_in = 0; eng_xfer_start = 1; tick(8'h00, 0, "R8 three-wire no conflict");

        four_wire = 1; is_master = 0; eng_xfer_active = 1;
                              tick(8'h00, 0, "R9 slave cs low idle");
        cs_in = 1;            tick(8'h01, 0, "R9 slave cs rise during transfer");
        eng_xfer_active = 0;
        sw_clear(8'h00, 8'h00, 0, "R11 slave conflict cleared");
        cs_in = 0;            tick(8'h00, 0, "R9 cs low no transfer");
        cs_in = 1;            tick(8'h00, 0, "R9 cs rise without transfer");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule